// File: doc/BRIEF.md
# Bridge Command Mailbox Register File

This block is the device-side control register file of a non-transparent bridge. A host on the far side of the bridge reaches it through a simple word-wide register bus. It drives configuration through a mailbox. The host first writes an argument word and then a command code. It polls a status field until that field shows success or error, and it then writes the field back to zero.

Inside the block, a command changes one of three pieces of state. These are the link flag, the doorbell setup (vector count and interrupt flavour) and the memory-window translation table. The table holds a 64-bit address, a 64-bit size and a valid flag for each window. The host stages the address and size of a window in four 32-bit registers, and a configure-window command copies them into the window that the argument names. The block rejects arguments that are out of range and leaves its state unchanged when it does.

The block also shows the window count, the offset of the first window, the scratchpad base offset and the scratchpad count as read-only constants. The translation datapath and interrupt delivery sit outside this block. They read the link, doorbell and window state from its output ports.

Top module: `bridge_cmd_mailbox`

## Requirements
- R1: After reset the status field (0x08) reads 0, the link field (0x0A) reads 0, link_up is 0, db_vec_count is 0 and no window is valid.
- R2: A read presents its data on bus_rdata with bus_rvalid high one cycle after the read is sampled. Offsets 0x20, 0x24, 0x28 and 0x2C return the window count, the first-window offset, the scratchpad base offset and the scratchpad count. These come from parameters NWIN, WIN0_OFS, SPAD_OFS and NSPAD.
- R3: A write to offset 0x00 when the block is idle starts a command. The code is the written word and the argument is the word last written to 0x04. The command's effect and its status appear exactly EXEC_LAT cycles after the accepting clock edge. Status bits [15:0] at 0x08 read 1 for success and 2 for error.
- R4: A write to 0x00 while a command is still executing is ignored and does not change the result of the running command.
- R5: Any write to 0x08 clears the status to 0. A command completing in the same cycle wins.
- R6: Code 5 sets the link flag and code 6 clears it. The flag is bit 0 of the word at 0x0A and is also driven on link_up. Both codes report success.
- R7: Code 1 configures doorbells. arg[15:0] is the total vector count (one link vector plus the doorbells) and must lie in 4..32, that is 3..31 doorbells. arg[16] set selects MSI-X and clear selects MSI. On success db_vec_count and db_msix take these values. Out of range reports error and changes neither.
- R8: Code 2 clears db_vec_count to 0 and reports success.
- R9: Code 3 with argument idx below NWIN copies the staged address ({0x14,0x10}) and size ({0x1C,0x18}) into window idx and sets its valid flag. The staged words read back at their offsets.
- R10: Code 4 with idx below NWIN clears that window's valid flag. Code 3 or 4 with idx of NWIN or more reports error and leaves every window unchanged.
- R11: Any other code, including 0 and 7 and above, reports error and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| link_up | output | 1 | Link flag |
| db_vec_count | output | 6 | Configured vector count, 0 when torn down |
| db_msix | output | 1 | 1 = MSI-X, 0 = MSI |
| win_valid | output | NWIN | Per-window valid flags |
| win_addr | output | NWIN*64 | Per-window translation address, window w at [w*64 +: 64] |
| win_size | output | NWIN*64 | Per-window size, window w at [w*64 +: 64] |

## Verification
A command accepted on clock edge k changes link, doorbell, window and status state on edge k+EXEC_LAT. Read data for a read sampled on edge j appears after edge j. The bench therefore idles EXEC_LAT cycles after each command write before it reads status, and it probes link_up one cycle early to show that the result is not visible before it is due. Read expectations are queued when the read is issued, and the monitor compares them on the falling edge after bus_rvalid rises. Port state is compared on falling edges after the completion edge.

// File: rtl/bmb_pkg.sv
package bmb_pkg;

  typedef enum logic [2:0] {
    OP_BAD     = 3'd0,
    OP_DB_SET  = 3'd1,
    OP_DB_CLR  = 3'd2,
    OP_WIN_SET = 3'd3,
    OP_WIN_CLR = 3'd4,
    OP_LNK_UP  = 3'd5,
    OP_LNK_DN  = 3'd6
  } op_e;

  localparam logic [7:0] A_CMD    = 8'h00;
  localparam logic [7:0] A_ARG    = 8'h04;
  localparam logic [7:0] A_STAT   = 8'h08;
  localparam logic [7:0] A_LINK   = 8'h0A;
  localparam logic [7:0] A_ADR_LO = 8'h10;
  localparam logic [7:0] A_ADR_HI = 8'h14;
  localparam logic [7:0] A_SZ_LO  = 8'h18;
  localparam logic [7:0] A_SZ_HI  = 8'h1C;
  localparam logic [7:0] A_NWIN   = 8'h20;
  localparam logic [7:0] A_W0OFS  = 8'h24;
  localparam logic [7:0] A_SPOFS  = 8'h28;
  localparam logic [7:0] A_NSPAD  = 8'h2C;

  localparam logic [15:0] ST_NONE = 16'd0;
  localparam logic [15:0] ST_OK   = 16'd1;
  localparam logic [15:0] ST_ERR  = 16'd2;

endpackage

// File: rtl/bmb_regbank.sv
module bmb_regbank
  import bmb_pkg::*;
#(
  parameter int          NWIN     = 4,
  parameter int          NSPAD    = 8,
  parameter logic [31:0] WIN0_OFS = 32'h0,
  parameter logic [31:0] SPAD_OFS = 32'h100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  input  logic [15:0] status,
  input  logic        link_up,
  output logic        cmd_wr,
  output logic [31:0] arg,
  output logic        stat_clr,
  output logic [63:0] stage_addr,
  output logic [63:0] stage_size
);

  logic [31:0] arg_q, adr_lo_q, adr_hi_q, sz_lo_q, sz_hi_q;
  logic [31:0] rdata_q, rdata_d;
  logic        rvalid_q;
  logic        arg_en, adr_lo_en, adr_hi_en, sz_lo_en, sz_hi_en;

  always_comb begin
    cmd_wr    = bus_wr && (bus_addr == A_CMD);
    stat_clr  = bus_wr && (bus_addr == A_STAT);
    arg_en    = bus_wr && (bus_addr == A_ARG);
    adr_lo_en = bus_wr && (bus_addr == A_ADR_LO);
    adr_hi_en = bus_wr && (bus_addr == A_ADR_HI);
    sz_lo_en  = bus_wr && (bus_addr == A_SZ_LO);
    sz_hi_en  = bus_wr && (bus_addr == A_SZ_HI);
  end

  always_comb begin
    unique case (bus_addr)
      A_ARG:    rdata_d = arg_q;
      A_STAT:   rdata_d = {16'h0, status};
      A_LINK:   rdata_d = {31'h0, link_up};
      A_ADR_LO: rdata_d = adr_lo_q;
      A_ADR_HI: rdata_d = adr_hi_q;
      A_SZ_LO:  rdata_d = sz_lo_q;
      A_SZ_HI:  rdata_d = sz_hi_q;
      A_NWIN:   rdata_d = 32'(NWIN);
      A_W0OFS:  rdata_d = WIN0_OFS;
      A_SPOFS:  rdata_d = SPAD_OFS;
      A_NSPAD:  rdata_d = 32'(NSPAD);
      default:  rdata_d = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q    <= '0;
      adr_lo_q <= '0;
      adr_hi_q <= '0;
      sz_lo_q  <= '0;
      sz_hi_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (arg_en)    arg_q    <= bus_wdata;
      if (adr_lo_en) adr_lo_q <= bus_wdata;
      if (adr_hi_en) adr_hi_q <= bus_wdata;
      if (sz_lo_en)  sz_lo_q  <= bus_wdata;
      if (sz_hi_en)  sz_hi_q  <= bus_wdata;
      if (bus_rd)    rdata_q  <= rdata_d;
      rvalid_q <= bus_rd;
    end
  end

  assign arg        = arg_q;
  assign stage_addr = {adr_hi_q, adr_lo_q};
  assign stage_size = {sz_hi_q, sz_lo_q};
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/bmb_sequencer.sv
module bmb_sequencer
  import bmb_pkg::*;
#(
  parameter int NWIN     = 4,
  parameter int MIN_DB   = 3,
  parameter int MAX_DB   = 31,
  parameter int EXEC_LAT = 3,
  parameter int VECW     = $clog2(MAX_DB + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic [31:0]     cmd_code,
  input  logic [31:0]     arg,
  input  logic            stat_clr,
  output logic            busy,
  output logic            done,
  output logic            done_ok,
  output op_e             done_op,
  output logic [31:0]     done_arg,
  output logic [VECW-1:0] done_vec,
  output logic            done_msix,
  output logic [15:0]     status
);

  localparam int CNTW = (EXEC_LAT > 1) ? $clog2(EXEC_LAT) : 1;

  logic            busy_q, busy_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  op_e             op_q, op_d, op_dec;
  logic [31:0]     arg_q;
  logic [15:0]     stat_q, stat_d;
  logic            accept, ok;

  always_comb begin
    unique case (cmd_code)
      32'd1:   op_dec = OP_DB_SET;
      32'd2:   op_dec = OP_DB_CLR;
      32'd3:   op_dec = OP_WIN_SET;
      32'd4:   op_dec = OP_WIN_CLR;
      32'd5:   op_dec = OP_LNK_UP;
      32'd6:   op_dec = OP_LNK_DN;
      default: op_dec = OP_BAD;
    endcase
  end

  always_comb begin
    accept = cmd_wr && !busy_q;
    done   = busy_q && (cnt_q == '0);
    unique case (op_q)
      OP_DB_SET:  ok = (arg_q[15:0] >= 16'(MIN_DB + 1)) &&
                       (arg_q[15:0] <= 16'(MAX_DB + 1));
      OP_WIN_SET,
      OP_WIN_CLR: ok = (arg_q < 32'(NWIN));
      OP_BAD:     ok = 1'b0;
      default:    ok = 1'b1;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    op_d   = op_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNTW'(EXEC_LAT - 1);
      op_d   = op_dec;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
    if (done)          stat_d = ok ? ST_OK : ST_ERR;
    else if (stat_clr) stat_d = ST_NONE;
    else               stat_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_BAD;
      arg_q  <= '0;
      stat_q <= ST_NONE;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      op_q   <= op_d;
      if (accept) arg_q <= arg;
      stat_q <= stat_d;
    end
  end

  assign busy      = busy_q;
  assign done_ok   = ok;
  assign done_op   = op_q;
  assign done_arg  = arg_q;
  assign done_vec  = arg_q[VECW-1:0];
  assign done_msix = arg_q[16];
  assign status    = stat_q;

endmodule

// File: rtl/bmb_link_db.sv
module bmb_link_db
  import bmb_pkg::*;
#(
  parameter int VECW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done,
  input  logic            done_ok,
  input  op_e             done_op,
  input  logic [VECW-1:0] done_vec,
  input  logic            done_msix,
  output logic            link_up,
  output logic [VECW-1:0] vec_count,
  output logic            msix
);

  logic            link_q, link_d, link_en;
  logic [VECW-1:0] vec_q, vec_d;
  logic            msix_q, msix_d, db_en;

  always_comb begin
    link_en = 1'b0;
    link_d  = link_q;
    db_en   = 1'b0;
    vec_d   = vec_q;
    msix_d  = msix_q;
    if (done && done_ok) begin
      unique case (done_op)
        OP_LNK_UP: begin link_en = 1'b1; link_d = 1'b1; end
        OP_LNK_DN: begin link_en = 1'b1; link_d = 1'b0; end
        OP_DB_SET: begin db_en = 1'b1; vec_d = done_vec; msix_d = done_msix; end
        OP_DB_CLR: begin db_en = 1'b1; vec_d = '0; end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      vec_q  <= '0;
      msix_q <= 1'b0;
    end else begin
      if (link_en) link_q <= link_d;
      if (db_en) begin
        vec_q  <= vec_d;
        msix_q <= msix_d;
      end
    end
  end

  assign link_up   = link_q;
  assign vec_count = vec_q;
  assign msix      = msix_q;

endmodule

// File: rtl/bmb_window_store.sv
module bmb_window_store
  import bmb_pkg::*;
#(
  parameter int NWIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              done_ok,
  input  op_e               done_op,
  input  logic [31:0]       done_arg,
  input  logic [63:0]       stage_addr,
  input  logic [63:0]       stage_size,
  output logic [NWIN-1:0]   win_valid,
  output logic [NWIN*64-1:0] win_addr,
  output logic [NWIN*64-1:0] win_size
);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic        hit, set_en, clr_en;
    logic        vld_q;
    logic [63:0] adr_q, sz_q;

    always_comb begin
      hit    = done && done_ok && (done_arg == 32'(w));
      set_en = hit && (done_op == OP_WIN_SET);
      clr_en = hit && (done_op == OP_WIN_CLR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        adr_q <= '0;
        sz_q  <= '0;
      end else begin
        if (set_en) begin
          vld_q <= 1'b1;
          adr_q <= stage_addr;
          sz_q  <= stage_size;
        end else if (clr_en) begin
          vld_q <= 1'b0;
        end
      end
    end

    assign win_valid[w]         = vld_q;
    assign win_addr[w*64 +: 64] = adr_q;
    assign win_size[w*64 +: 64] = sz_q;
  end

endmodule

// File: rtl/bridge_cmd_mailbox.sv
module bridge_cmd_mailbox
  import bmb_pkg::*;
#(
  parameter int          NWIN     = 4,
  parameter int          NSPAD    = 8,
  parameter logic [31:0] WIN0_OFS = 32'h0000_0000,
  parameter logic [31:0] SPAD_OFS = 32'h0000_0100,
  parameter int          MIN_DB   = 3,
  parameter int          MAX_DB   = 31,
  parameter int          EXEC_LAT = 3,
  localparam int         VECW     = $clog2(MAX_DB + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  output logic               link_up,
  output logic [VECW-1:0]    db_vec_count,
  output logic               db_msix,
  output logic [NWIN-1:0]    win_valid,
  output logic [NWIN*64-1:0] win_addr,
  output logic [NWIN*64-1:0] win_size
);

  logic        rst_meta_n, rst_sync_n;
  logic        cmd_wr, stat_clr;
  logic [31:0] arg;
  logic [63:0] stage_addr, stage_size;
  logic        seq_busy, seq_done, seq_ok, seq_msix;
  op_e         seq_op;
  logic [31:0] seq_arg;
  logic [VECW-1:0] seq_vec;
  logic [15:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  bmb_regbank #(
    .NWIN(NWIN), .NSPAD(NSPAD), .WIN0_OFS(WIN0_OFS), .SPAD_OFS(SPAD_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .status(status), .link_up(link_up),
    .cmd_wr(cmd_wr), .arg(arg), .stat_clr(stat_clr),
    .stage_addr(stage_addr), .stage_size(stage_size)
  );

  bmb_sequencer #(
    .NWIN(NWIN), .MIN_DB(MIN_DB), .MAX_DB(MAX_DB), .EXEC_LAT(EXEC_LAT), .VECW(VECW)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .cmd_wr(cmd_wr), .cmd_code(bus_wdata), .arg(arg), .stat_clr(stat_clr),
    .busy(seq_busy), .done(seq_done), .done_ok(seq_ok), .done_op(seq_op),
    .done_arg(seq_arg), .done_vec(seq_vec), .done_msix(seq_msix),
    .status(status)
  );

  bmb_link_db #(.VECW(VECW)) u_lnk (
    .clk(clk), .rst_n(rst_sync_n),
    .done(seq_done), .done_ok(seq_ok), .done_op(seq_op),
    .done_vec(seq_vec), .done_msix(seq_msix),
    .link_up(link_up), .vec_count(db_vec_count), .msix(db_msix)
  );

  bmb_window_store #(.NWIN(NWIN)) u_win (
    .clk(clk), .rst_n(rst_sync_n),
    .done(seq_done), .done_ok(seq_ok), .done_op(seq_op), .done_arg(seq_arg),
    .stage_addr(stage_addr), .stage_size(stage_size),
    .win_valid(win_valid), .win_addr(win_addr), .win_size(win_size)
  );

endmodule

// File: rtl/bmb_checker.sv
module bmb_checker #(
  parameter int NWIN     = 4,
  parameter int MIN_DB   = 3,
  parameter int MAX_DB   = 31,
  parameter int EXEC_LAT = 3,
  parameter int VECW     = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [7:0]      bus_addr,
  input logic            busy,
  input logic            done,
  input logic [15:0]     status,
  input logic            link_up,
  input logic [VECW-1:0] db_vec_count,
  input logic [NWIN-1:0] win_valid
);

  localparam int CKW = $clog2(EXEC_LAT + 2) + 1;
  localparam logic [CKW-1:0] CKMAX = {CKW{1'b1}};

  logic [CKW-1:0] ck_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_cnt <= '0;
    else if (bus_wr && (bus_addr == 8'h00) && !busy) ck_cnt <= CKW'(1);
    else if ((ck_cnt != '0) && (ck_cnt != CKMAX)) ck_cnt <= ck_cnt + 1'b1;
  end

  // R3: status only ever holds none, ok or error
  assert_status_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status <= 16'd2);

  // R3: completion falls exactly EXEC_LAT edges after the accepting edge
  assert_exec_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ck_cnt == CKW'(EXEC_LAT)));

  // R5: a status write with no completion leaves status at zero
  assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == 8'h08) && !done) |=> (status == 16'd0));

  // R6: link flag moves only when a command completes
  assert_link_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(link_up));

  // R7: a configured vector count always lies in the legal range
  assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (db_vec_count != '0) |-> ((db_vec_count >= VECW'(MIN_DB + 1)) &&
                              (db_vec_count <= VECW'(MAX_DB + 1))));

  // R10: window valid flags move only when a command completes
  assert_win_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(win_valid));

endmodule

bind bridge_cmd_mailbox bmb_checker #(
  .NWIN(NWIN), .MIN_DB(MIN_DB), .MAX_DB(MAX_DB), .EXEC_LAT(EXEC_LAT), .VECW(VECW)
) u_bmb_checker (
  .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .busy(seq_busy), .done(seq_done), .status(status), .link_up(link_up),
  .db_vec_count(db_vec_count), .win_valid(win_valid)
);

// File: tb/test_bridge_cmd_mailbox.sv
module test_bridge_cmd_mailbox;

  localparam int          NWIN  = 4;
  localparam int          NSPAD = 8;
  localparam logic [31:0] W0OFS = 32'h0000_0000;
  localparam logic [31:0] SPOFS = 32'h0000_0100;
  localparam int          LAT   = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               bus_wr = 1'b0;
  logic               bus_rd = 1'b0;
  logic [7:0]         bus_addr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic               bus_rvalid;
  logic               link_up;
  logic [5:0]         db_vec_count;
  logic               db_msix;
  logic [NWIN-1:0]    win_valid;
  logic [NWIN*64-1:0] win_addr;
  logic [NWIN*64-1:0] win_size;

  bridge_cmd_mailbox i_bridge_cmd_mailbox (.*);

  always #10 clk = ~clk;

  int unsigned vectors = 0;
  int unsigned miscompares = 0;
  bit          finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R2: unexpected read data, actual %0h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {32'h0, bus_rdata}, {32'h0, e});
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // command, wait for completion, check and clear status
  task automatic run(input logic [31:0] code, input logic [31:0] a,
                     input logic [31:0] st, input string tag);
    wr(8'h04, a);
    wr(8'h00, code);
    idle(LAT);
    rd(8'h08, st, tag);
    wr(8'h08, 32'h0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(8'h08, 32'h0, "R1 status after reset");
    rd(8'h0A, 32'h0, "R1 link after reset");
    chk("R1 link_up port", {63'h0, link_up}, 64'h0);
    chk("R1 db_vec_count", {58'h0, db_vec_count}, 64'h0);
    chk("R1 win_valid", {60'h0, win_valid}, 64'h0);

    // R2 read-only constants
    rd(8'h20, 32'(NWIN), "R2 window count");
    rd(8'h24, W0OFS, "R2 first window offset");
    rd(8'h28, SPOFS, "R2 scratchpad offset");
    rd(8'h2C, 32'(NSPAD), "R2 scratchpad count");

    // R3 latency, R6 link up
    wr(8'h04, 32'h0);
    wr(8'h00, 32'd5);
    idle(LAT - 1);
    chk("R3 link_up not yet set", {63'h0, link_up}, 64'h0);
    idle(1);
    chk("R3 R6 link_up set on time", {63'h0, link_up}, 64'h1);
    rd(8'h08, 32'd1, "R3 status ok after link up");
    rd(8'h0A, 32'h1, "R6 link field up");
    // R5 clear
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h0, "R5 status cleared");

    // R4 second command while busy ignored
    wr(8'h04, 32'h0);
    wr(8'h00, 32'd6);
    wr(8'h00, 32'd5);
    idle(LAT);
    chk("R4 R6 link down, busy write ignored", {63'h0, link_up}, 64'h0);
    rd(8'h08, 32'd1, "R4 status from first command");
    wr(8'h08, 32'h0);
    idle(LAT + 2);
    chk("R4 link stays down", {63'h0, link_up}, 64'h0);
    rd(8'h0A, 32'h0, "R6 link field down");

    // R7 doorbell configure
    run(32'd1, 32'h0001_0005, 32'd1, "R7 doorbell 5 vectors msix ok");
    chk("R7 vec count 5", {58'h0, db_vec_count}, 64'd5);
    chk("R7 msix set", {63'h0, db_msix}, 64'h1);
    run(32'd1, 32'h0000_0003, 32'd2, "R7 3 vectors rejected");
    chk("R7 vec count kept", {58'h0, db_vec_count}, 64'd5);
    chk("R7 msix kept", {63'h0, db_msix}, 64'h1);
    run(32'd1, 32'h0000_0021, 32'd2, "R7 33 vectors rejected");
    chk("R7 vec count kept after 33", {58'h0, db_vec_count}, 64'd5);
    run(32'd1, 32'h0000_0020, 32'd1, "R7 32 vectors msi ok");
    chk("R7 vec count 32", {58'h0, db_vec_count}, 64'd32);
    chk("R7 msi selected", {63'h0, db_msix}, 64'h0);
    run(32'd1, 32'h0000_0004, 32'd1, "R7 4 vectors ok");
    chk("R7 vec count 4", {58'h0, db_vec_count}, 64'd4);

    // R8 doorbell teardown
    run(32'd2, 32'h0, 32'd1, "R8 teardown ok");
    chk("R8 vec count cleared", {58'h0, db_vec_count}, 64'd0);

    // R9 window configure
    wr(8'h10, 32'h8000_1000);
    wr(8'h14, 32'h0000_0012);
    wr(8'h18, 32'h0010_0000);
    wr(8'h1C, 32'h0000_0003);
    rd(8'h14, 32'h0000_0012, "R9 staged address high readback");
    rd(8'h18, 32'h0010_0000, "R9 staged size low readback");
    run(32'd3, 32'd2, 32'd1, "R9 window 2 ok");
    chk("R9 window 2 valid", {60'h0, win_valid}, 64'h4);
    chk("R9 window 2 address", win_addr[2*64 +: 64], 64'h0000_0012_8000_1000);
    chk("R9 window 2 size", win_size[2*64 +: 64], 64'h0000_0003_0010_0000);

    // R10 window range and teardown
    run(32'd3, 32'(NWIN), 32'd2, "R10 window index at count rejected");
    chk("R10 windows unchanged", {60'h0, win_valid}, 64'h4);
    run(32'd4, 32'd7, 32'd2, "R10 teardown index 7 rejected");
    chk("R10 windows unchanged after bad teardown", {60'h0, win_valid}, 64'h4);
    run(32'd4, 32'd2, 32'd1, "R10 teardown window 2 ok");
    chk("R10 window 2 cleared", {60'h0, win_valid}, 64'h0);

    // R11 unknown codes
    run(32'd5, 32'h0, 32'd1, "R11 link up before bad codes");
    run(32'd9, 32'h0, 32'd2, "R11 code 9 rejected");
    run(32'd0, 32'h0, 32'd2, "R11 code 0 rejected");
    chk("R11 link unchanged", {63'h0, link_up}, 64'h1);
    chk("R11 vec count unchanged", {58'h0, db_vec_count}, 64'd0);

    idle(4);
    chk("R2 all reads answered", 64'(exp_q.size()), 64'h0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule